// File: doc/BRIEF.md
# Multi-bit ECC Correction Sequencer

This block drives one page-chunk correction pass against an external multi-bit error-locator engine. A `start` pulse captures the 80-bit stored check code that was read back with a 512-byte data chunk. A code made entirely of 0xFF bytes marks an erased chunk, which needs no correction. Any other code is cut into eight 10-bit check values, and these are handed to the engine one per cycle, highest index first. The sequencer then reads the engine's syndrome. A zero syndrome ends the pass at once. A non-zero syndrome makes the sequencer start the engine's address calculation.

The engine's 4-bit state field can read as "addresses ready" for a short time before the engine has really begun work. For that reason the sequencer first waits for a busy state, giving up after a set number of cycles, and only then decodes the field. Once the engine reports ready, the sequencer walks through up to four (address, value) pairs. It turns each reversed 10-bit address into a byte index and issues an XOR write to the data buffer for each index inside the chunk. Indices that fall in the parity area are dropped. The pass ends with a one-cycle `done` pulse, the number of bytes corrected and a fail flag.

Top module: `ecc_fix_seq`

## Requirements
- R1: When all ten bytes of the captured code are 0xFF, the pass ends with `done`, a count of 0 and `fail` low, with no load and no `calc_start`.
- R2: The code is taken with byte j at bits [8j+7:8j]. Check value k (0..7) is code bits [10k+9:10k], which is the same as reading five little-endian 16-bit words and splitting them lowest bits first.
- R3: The eight check values are presented on `eng_load_data` with `eng_load_valid` high on eight consecutive cycles, in the order value 7, 6, down to 0.
- R4: Each of the four 32-bit syndrome words (word w at `syn_in[32w+31:32w]`) is masked to bits [25:16] and [9:0]. If all masked words are zero, the pass ends with a count of 0 and no `calc_start`.
- R5: After the one-cycle `calc_start`, the sequencer keeps waiting while `eng_state` is below 4, for at most TIMEOUT_CYC cycles. A state of 3 seen in this window is not taken as ready.
- R6: If the wait window expires, the next cycle decodes `eng_state` directly. With a state held below 4, `done` follows the `calc_start` cycle by exactly TIMEOUT_CYC+2+n cycles, where n is 0 for state 0 and the error total for states 2 and 3.
- R7: Decoding works as follows. State 0 ends with no correction. State 1 ends with `fail` high and a count of 0. States 2 and 3 mean the addresses are ready. States 4 to 15 keep the sequencer polling.
- R8: The error total is 1 plus `eng_count`, sampled in the cycle that reads the ready state. Every error up to that total is visited, one per cycle.
- R9: Errors 0 and 1 take their address and value from `err_addr_a`/`err_val_a`, and errors 2 and 3 from `err_addr_b`/`err_val_b`. Even-numbered errors use bits [15:0] and odd-numbered errors use bits [31:16]. Of each half, the address uses bits [9:0] and the value uses bits [7:0].
- R10: The byte index is 519 minus the 10-bit address. Only addresses 8 to 519 (index 0 to 511) produce an `xor_we` write with that index and value, and only these are counted in `fix_count`.
- R11: `done` is high for exactly one cycle per pass, and `fix_count` and `fail` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a pass; ignored while a pass is running |
| code_in | input | 80 | Stored check code, byte 0 in the low bits |
| eng_load_valid | output | 1 | A check value is being loaded into the engine |
| eng_load_data | output | 10 | Check value being loaded |
| syn_in | input | 128 | Four syndrome words from the engine |
| calc_start | output | 1 | One-cycle start of address calculation |
| eng_state | input | 4 | Engine state field |
| eng_count | input | 2 | Engine error count field (total minus one) |
| err_addr_a | input | 32 | Addresses of errors 0 (low half) and 1 (high half) |
| err_addr_b | input | 32 | Addresses of errors 2 (low half) and 3 (high half) |
| err_val_a | input | 32 | Values of errors 0 and 1 |
| err_val_b | input | 32 | Values of errors 2 and 3 |
| xor_we | output | 1 | XOR write strobe to the data buffer |
| xor_idx | output | 9 | Byte index of the XOR write |
| xor_val | output | 8 | Mask to XOR into that byte |
| done | output | 1 | One-cycle end of pass |
| fix_count | output | 3 | Number of bytes corrected in the pass |
| fail | output | 1 | Too many errors to correct |

## Verification
The hardest case to reach from the ports is the engine's false "ready" reading right after `calc_start`. A sequencer that decodes too early still finishes cleanly, just with the wrong data. To expose it, the bench's engine responder shows state 3 for a few cycles, paired with a zero count and decoy address registers that point inside the chunk. Only then does it go busy and present the real result, so an early decode produces an XOR write the bench does not expect. The timeout path is reached by holding the state at 3, or at 0, with the true registers visible, and checking the exact cycle distance from `calc_start` to `done`.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

  localparam int NVAL      = 8;
  localparam int VW        = 10;
  localparam int CODE_W    = NVAL * VW;
  localparam int NSYN      = 4;
  localparam int SYN_W     = NSYN * 32;
  localparam int BUF_BYTES = 512;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int BIAS      = BUF_BYTES + 7;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_LOAD, S_SYND, S_KICK, S_SETTLE, S_POLL, S_FIX, S_FIN
  } state_t;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] idx;
  } hit_t;

  // Reversed engine address -> data byte index; ok only inside the chunk.
  function automatic hit_t map_err_addr(input logic [VW-1:0] a);
    hit_t       h;
    logic [VW:0] d;
    d     = (VW+1)'(BIAS) - {1'b0, a};
    h.ok  = ({1'b0, a} <= (VW+1)'(BIAS)) && (d < (VW+1)'(BUF_BYTES));
    h.idx = d[IDX_W-1:0];
    return h;
  endfunction

  // Syndrome is clear when every word's two 10-bit fields are zero.
  function automatic logic syn_is_clear(input logic [SYN_W-1:0] s);
    logic acc;
    acc = 1'b0;
    for (int w = 0; w < NSYN; w++)
      acc = acc | (|s[32*w +: VW]) | (|s[32*w+16 +: VW]);
    return !acc;
  endfunction

endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack #(
  parameter int NV = 8,
  parameter int W  = 10
) (
  input  logic [NV*W-1:0]       code,
  output logic [NV-1:0][W-1:0]  vals
);
  for (genvar k = 0; k < NV; k++) begin : g_slice
    assign vals[k] = code[k*W +: W];
  end
endmodule

// File: rtl/ecc_settle_timer.sv
module ecc_settle_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ecc_err_pick.sv
module ecc_err_pick
  import ecc_seq_pkg::*;
(
  input  logic [1:0]       sel,
  input  logic [31:0]      addr_a,
  input  logic [31:0]      addr_b,
  input  logic [31:0]      val_a,
  input  logic [31:0]      val_b,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       val
);
  logic [31:0] areg, vreg;
  logic [15:0] ahalf, vhalf;
  hit_t        m;
  logic        unused_pick;

  always_comb begin
    areg  = sel[1] ? addr_b : addr_a;
    vreg  = sel[1] ? val_b  : val_a;
    ahalf = sel[0] ? areg[31:16] : areg[15:0];
    vhalf = sel[0] ? vreg[31:16] : vreg[15:0];
    m     = map_err_addr(ahalf[VW-1:0]);
  end

  assign hit = m.ok;
  assign idx = m.idx;
  assign val = vhalf[7:0];
  assign unused_pick = ^{ahalf[15:VW], vhalf[15:8]};
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CODE_W-1:0]    code_in,
  output logic                 eng_load_valid,
  output logic [VW-1:0]        eng_load_data,
  input  logic [SYN_W-1:0]     syn_in,
  output logic                 calc_start,
  input  logic [3:0]           eng_state,
  input  logic [1:0]           eng_count,
  input  logic [31:0]          err_addr_a,
  input  logic [31:0]          err_addr_b,
  input  logic [31:0]          err_val_a,
  input  logic [31:0]          err_val_b,
  output logic                 xor_we,
  output logic [IDX_W-1:0]     xor_idx,
  output logic [7:0]           xor_val,
  output logic                 done,
  output logic [2:0]           fix_count,
  output logic                 fail
);
  localparam int LW = $clog2(NVAL);

  state_t                  st;
  logic [CODE_W-1:0]       code_q;
  logic [NVAL-1:0][VW-1:0] vals;
  logic [LW-1:0]           ld_idx;
  logic [2:0]              err_total;
  logic [1:0]              fix_i;
  logic [2:0]              cnt_q;
  logic                    fail_q;

  // named internal events
  logic code_erased, syn_clear, eng_busy, tmr_expired, settle_leave;
  logic pick_hit, last_err;

  ecc_code_unpack #(.NV(NVAL), .W(VW)) u_unpack (
    .code(code_q), .vals(vals)
  );

  ecc_settle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st == S_KICK), .run(st == S_SETTLE),
    .expired(tmr_expired)
  );

  ecc_err_pick u_pick (
    .sel(fix_i), .addr_a(err_addr_a), .addr_b(err_addr_b),
    .val_a(err_val_a), .val_b(err_val_b),
    .hit(pick_hit), .idx(xor_idx), .val(xor_val)
  );

  assign code_erased  = &code_q;
  assign syn_clear    = syn_is_clear(syn_in);
  assign eng_busy     = eng_state[3] | eng_state[2];
  assign settle_leave = eng_busy | tmr_expired;
  assign last_err     = ({1'b0, fix_i} == (err_total - 3'd1));

  assign eng_load_valid = (st == S_LOAD);
  assign eng_load_data  = vals[ld_idx];
  assign calc_start     = (st == S_KICK);
  assign xor_we         = (st == S_FIX) && pick_hit;
  assign done           = (st == S_FIN);
  assign fix_count      = cnt_q;
  assign fail           = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      code_q    <= '0;
      ld_idx    <= '0;
      err_total <= 3'd1;
      fix_i     <= '0;
      cnt_q     <= '0;
      fail_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          code_q <= code_in;
          cnt_q  <= '0;
          fail_q <= 1'b0;
          st     <= S_SCAN;
        end
        S_SCAN: begin
          ld_idx <= LW'(NVAL - 1);
          st     <= code_erased ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          if (ld_idx == '0) st <= S_SYND;
          else              ld_idx <= ld_idx - 1'b1;
        end
        S_SYND:   st <= syn_clear ? S_FIN : S_KICK;
        S_KICK:   st <= S_SETTLE;
        S_SETTLE: if (settle_leave) st <= S_POLL;
        S_POLL: begin
          case (eng_state)
            4'd0: st <= S_FIN;
            4'd1: begin fail_q <= 1'b1; st <= S_FIN; end
            4'd2, 4'd3: begin
              err_total <= {1'b0, eng_count} + 3'd1;
              fix_i     <= '0;
              st        <= S_FIX;
            end
            default: st <= S_POLL;
          endcase
        end
        S_FIX: begin
          if (pick_hit) cnt_q <= cnt_q + 3'd1;
          if (last_err) st <= S_FIN;
          else          fix_i <= fix_i + 2'd1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_fix_seq_chk.sv
module ecc_fix_seq_chk
  import ecc_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input state_t     st,
  input logic [2:0] ld_idx,
  input logic       eng_load_valid,
  input logic       code_erased,
  input logic       tmr_expired,
  input logic [3:0] eng_state,
  input logic       done,
  input logic       fail,
  input logic [2:0] fix_count
);
  assert_erased_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && code_erased) |=> (done && fix_count == 3'd0 && !fail));

  assert_load_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_load_valid && $past(eng_load_valid)) |-> (ld_idx == $past(ld_idx) - 3'd1));

  assert_settle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && eng_state < 4'd4 && !tmr_expired) |=> (st == S_SETTLE));

  assert_timeout_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && tmr_expired) |=> (st == S_POLL));

  assert_fail_nofix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (fix_count == 3'd0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ecc_fix_seq ecc_fix_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ld_idx(ld_idx),
  .eng_load_valid(eng_load_valid), .code_erased(code_erased),
  .tmr_expired(tmr_expired), .eng_state(eng_state), .done(done),
  .fail(fail), .fix_count(fix_count)
);

// File: tb/sim_ecc_fix_seq.sv
module sim_ecc_fix_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [79:0]  code_in = '0;
  logic         eng_load_valid;
  logic [9:0]   eng_load_data;
  logic [127:0] syn_in = '0;
  logic         calc_start;
  logic [3:0]   eng_state = '0;
  logic [1:0]   eng_count = '0;
  logic [31:0]  err_addr_a = '0, err_addr_b = '0, err_val_a = '0, err_val_b = '0;
  logic         xor_we;
  logic [8:0]   xor_idx;
  logic [7:0]   xor_val;
  logic         done;
  logic [2:0]   fix_count;
  logic         fail;

  ecc_fix_seq #(.TIMEOUT_CYC(TMO)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // responder script
  int          r_pre = 0, r_busy = 0;
  logic [3:0]  r_pre_st = 4'd3, r_fstate = 4'd0;
  logic [1:0]  r_fcount = 2'd0;
  logic [31:0] r_addr_a = 0, r_addr_b = 0, r_val_a = 0, r_val_b = 0;
  bit          r_honest = 0;
  bit          active = 0;
  int          ph = 0;

  always @(negedge clk) begin
    if (calc_start) begin active = 1; ph = 0; end
    if (done) active = 0;
    if (active) begin
      bit fin;
      fin = (ph >= r_pre + r_busy);
      if (ph < r_pre)               eng_state = r_pre_st;
      else if (ph < r_pre + r_busy) eng_state = 4'd9;
      else                          eng_state = r_fstate;
      if (r_honest || fin) begin
        eng_count = r_fcount; err_addr_a = r_addr_a; err_addr_b = r_addr_b;
        err_val_a = r_val_a;  err_val_b = r_val_b;
      end else begin
        eng_count = 2'd0; err_addr_a = 32'h0100_0100; err_addr_b = 32'h0100_0100;
        err_val_a = 32'h00EE_00EE; err_val_b = 32'h00EE_00EE;
      end
      ph++;
    end else eng_state = 4'd0;
  end

  // monitor
  int ld_n, wr_n, calc_n, done_n, lat, lat_done;
  bit lat_on, got_done;
  int ld_log[16], wr_idx[16], wr_val[16];
  int got_cnt, got_fail;

  always @(negedge clk) begin
    if (eng_load_valid) begin if (ld_n < 16) ld_log[ld_n] = eng_load_data; ld_n++; end
    if (xor_we) begin
      if (wr_n < 16) begin wr_idx[wr_n] = xor_idx; wr_val[wr_n] = xor_val; end
      wr_n++;
    end
    if (calc_start) begin calc_n++; lat = 0; lat_on = 1; end
    else if (lat_on) lat++;
    if (done) begin
      done_n++; got_done = 1; got_cnt = fix_count; got_fail = fail;
      lat_done = lat; lat_on = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [79:0] code, input logic [127:0] syn, input int lat_exp);
    int ev[8]; int e_idx[4]; int e_val[4];
    int e_ld, e_calc, e_cnt, e_fail, e_wn, nerr;
    bit erased, synz;
    erased = &code;
    for (int k = 0; k < 8; k++) begin
      ev[k] = 0;
      for (int b = 0; b < 10; b++) begin
        int p; p = 10*k + b;
        if (code[8*(p/8) + (p%8)]) ev[k] += (1 << b);
      end
    end
    synz = 1;
    for (int w = 0; w < 4; w++) if ((syn[32*w +: 32] & 32'h03ff03ff) != 0) synz = 0;
    e_cnt = 0; e_fail = 0; e_wn = 0; nerr = 0;
    if (erased)    begin e_ld = 0; e_calc = 0; end
    else if (synz) begin e_ld = 8; e_calc = 0; end
    else begin
      e_ld = 8; e_calc = 1;
      if (r_fstate == 4'd1) e_fail = 1;
      else if (r_fstate == 4'd2 || r_fstate == 4'd3) begin
        nerr = r_fcount + 1;
        for (int k = 0; k < nerr; k++) begin
          int a, v, ix; logic [31:0] ar, vr;
          ar = (k > 1) ? r_addr_b : r_addr_a;
          vr = (k > 1) ? r_val_b  : r_val_a;
          a  = (ar >> (16*(k%2))) & 1023;
          v  = (vr >> (16*(k%2))) & 255;
          ix = 519 - a;
          if (ix >= 0 && ix < 512) begin e_idx[e_wn] = ix; e_val[e_wn] = v; e_wn++; end
        end
        e_cnt = e_wn;
      end
    end

    @(negedge clk);
    ld_n = 0; wr_n = 0; calc_n = 0; done_n = 0; got_done = 0; lat_on = 0;
    code_in = code; syn_in = syn; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 600 && !got_done; c++) @(posedge clk);
    @(posedge clk); @(posedge clk);

    chk("R11 done seen", got_done, 1);
    chk("R11 single done", done_n, got_done ? 1 : 0);
    chk("R10 fix_count", got_cnt, e_cnt);
    chk("R7 fail", got_fail, e_fail);
    chk("R1/R3 load count", ld_n, e_ld);
    if (ld_n == e_ld)
      for (int j = 0; j < e_ld; j++) chk("R2/R3 load value", ld_log[j], ev[7-j]);
    chk("R4 calc_start count", calc_n, e_calc);
    chk("R9/R10 write count", wr_n, e_wn);
    if (wr_n == e_wn)
      for (int j = 0; j < e_wn; j++) begin
        chk("R10 write index", wr_idx[j], e_idx[j]);
        chk("R9 write value", wr_val[j], e_val[j]);
      end
    if (lat_exp >= 0) chk("R6 timeout latency", lat_done, lat_exp);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [79:0] rnd_code();
    logic [79:0] c;
    for (int i = 0; i < 3; i++) begin seed = lcg(seed); c[32*i +: 32] = (i == 2) ? {16'h0, seed[31:16]} : seed; end
    c[79:64] = seed[15:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_pair(input int lo, input int hi);
    logic [31:0] r;
    seed = lcg(seed);
    r = {seed[31:26], 10'(hi), seed[25:20], 10'(lo)};
    return r;
  endfunction

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    int apat[4][4];
    apat[0] = '{0, 7, 8, 9};
    apat[1] = '{519, 520, 1023, 263};
    apat[2] = '{100, 511, 518, 300};
    apat[3] = '{12, 400, 64, 9};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R3 reset load", eng_load_valid, 0);
    chk("R4 reset calc", calc_start, 0);
    chk("R10 reset we", xor_we, 0);
    chk("R10 reset count", fix_count, 0);
    chk("R7 reset fail", fail, 0);

    // R1 erased, and near-erased
    run_case({80{1'b1}}, 128'h1, -1);
    run_case({{72{1'b1}}, 8'hFE}, 128'h0, -1);

    // R2 R3 R4: unpack sweep with clear syndrome, masked bits only
    for (int t = 0; t < 16; t++) run_case(rnd_code(), 128'h0, -1);
    run_case(rnd_code(), {4{32'hFC00_FC00}}, -1);

    // R5 R7 R8 R9 R10: status and address sweep, decoy ready before busy
    r_honest = 0; r_pre = 3; r_pre_st = 4'd3; r_busy = 3;
    for (int fs = 0; fs < 4; fs++)
      for (int fc = 0; fc < 4; fc++)
        for (int p = 0; p < 4; p++) begin
          r_fstate = 4'(fs); r_fcount = 2'(fc);
          r_addr_a = pack_pair(apat[p][0], apat[p][1]);
          r_addr_b = pack_pair(apat[p][2], apat[p][3]);
          seed = lcg(seed); r_val_a = seed;
          seed = lcg(seed); r_val_b = seed;
          run_case(rnd_code(), 128'h0000_0400_0000_0000_0000_0000_0000_0000 | 128'(p + 1), -1);
        end

    // R7 busy with no preceding decoy
    r_pre = 0; r_busy = 7; r_fstate = 4'd2; r_fcount = 2'd1;
    run_case(rnd_code(), 128'h8, -1);

    // R6 timeout: held below 4 with real registers visible
    r_honest = 1; r_pre = 100000; r_busy = 0;
    r_pre_st = 4'd0; r_fstate = 4'd0;
    run_case(rnd_code(), 128'h2, TMO + 2);
    r_pre_st = 4'd3; r_fstate = 4'd3; r_fcount = 2'd3;
    r_addr_a = pack_pair(519, 8); r_addr_b = pack_pair(7, 200);
    r_val_a = 32'h0011_0022; r_val_b = 32'h0033_0044;
    run_case(rnd_code(), 128'h2, TMO + 2 + 4);
    r_pre_st = 4'd1; r_fstate = 4'd1;
    run_case(rnd_code(), 128'h2, TMO + 2);

    finish_up();
  end
endmodule